// File: doc/BRIEF.md
# Atomic Bit-Operation Register Bank

This block is a bank of 32-bit control registers that sits on a simple valid/ready request bus. It drives the current value of every register straight out to the logic it controls. Each register can be reached through four address windows. One window gives plain full-word reads and writes. The other three turn a bus write into a single-cycle set, clear or toggle of only those bits that are 1 in the write data. Software can therefore change a few bits of a shared register in one write, with no read-modify-write sequence that a second requester could interleave with.

Two upper address bits choose the window and the word-address bits choose the register. Reads through any window return the register's value one cycle after the request is accepted, and they have no side effect. Addresses beyond the implemented registers accept writes without effect and read as zero.

Top module: `regbank_alias`

## Requirements
- R1: Address bits [13:12] select the window (00 plain, 01 toggle, 10 set, 11 clear), and bits [11:2] select register index k. A plain-window write stores the full 32-bit write data into register k.
- R2: A set-window write makes register k equal to its old value OR the write data.
- R3: A clear-window write makes register k equal to its old value AND the inverse of the write data.
- R4: A toggle-window write makes register k equal to its old value XOR the write data.
- R5: A read through any of the four windows returns register k's current value on rsp_rdata, with rsp_valid high, in the cycle after the request is accepted. The read changes no register.
- R6: Bits that are 0 in the write data of a set, clear or toggle write keep their value. A masked field update done as one toggle write of ((current ^ new) & mask) changes only the bits inside the mask.
- R7: When the index is NUM_REGS or higher, a write is accepted and changes no register, and a read returns zero.
- R8: Writes accepted in consecutive cycles take effect in order, each one applied in full to the result of the one before.
- R9: A synchronous active-high reset clears every register and rsp_valid. req_ready stays high, so a request completes in the cycle in which req_valid is high. Register k appears on regs_out bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte address: window in [13:12], register index in [11:2] |
| req_wdata | input | 32 | Write data, or bit mask for the alias windows |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| regs_out | output | NUM_REGS*32 | Current register values, register k in bits [32k+31:32k] |

## Verification
The hardest case to reach from the ports is two alias writes from different requesters that land on the same register in consecutive cycles. Here the second operation has to see the result of the first and not a stale value. The bench drives a toggle write and then a set write with no idle cycle between them, and it chooses masks for which applying the two in the wrong order gives a different value. It also drives a set and a clear back to back. The masked field update is built from a value read back through the bus, and the bench then compares the bits outside the mask with that value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int WIN_W = 2;

    // Window codes carried in the upper address bits
    typedef enum logic [WIN_W-1:0] {
        WIN_PLAIN  = 2'b00,
        WIN_TOGGLE = 2'b01,
        WIN_SET    = 2'b10,
        WIN_CLEAR  = 2'b11
    } win_e;

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int WIN_LSB  = 12,
    parameter int IDX_LSB  = 2,
    localparam int IDX_W   = WIN_LSB - IDX_LSB
) (
    input  logic [WIN_LSB+WIN_W-1:IDX_LSB] addr_hi,
    output win_e                          win,
    output logic [IDX_W-1:0]              idx,
    output logic                          hit
);

    always_comb begin
        win = win_e'(addr_hi[WIN_LSB +: WIN_W]);
        idx = addr_hi[WIN_LSB-1:IDX_LSB];
        hit = (32'(idx) < 32'(NUM_REGS));
    end

endmodule

// File: rtl/regbank_bitop.sv
module regbank_bitop
    import regbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  win_e              op,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] nxt
);

    always_comb begin
        unique case (op)
            WIN_PLAIN:  nxt = mask;
            WIN_TOGGLE: nxt = cur ^ mask;
            WIN_SET:    nxt = cur | mask;
            WIN_CLEAR:  nxt = cur & ~mask;
            default:    nxt = cur;
        endcase
    end

endmodule

// File: rtl/regbank_alias.sv
module regbank_alias
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    parameter int IDX_LSB  = 2,
    parameter int WIN_LSB  = 12,
    localparam int ADDR_W  = WIN_LSB + WIN_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic [NUM_REGS*DATA_W-1:0] regs_out
);

    localparam int IDX_W = WIN_LSB - IDX_LSB;
    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            rsp_valid;
        word_t                           rsp_rdata;
    } state_t;

    state_t st_d, st_q;

    win_e             win;
    logic [IDX_W-1:0] idx;
    logic             hit;
    logic [SEL_W-1:0] sel;
    word_t            sel_val;
    word_t            upd_val;
    logic             accept;
    logic             unused_lsb;

    assign unused_lsb = ^req_addr[IDX_LSB-1:0];

    regbank_decode #(
        .NUM_REGS (NUM_REGS),
        .WIN_LSB  (WIN_LSB),
        .IDX_LSB  (IDX_LSB)
    ) u_decode (
        .addr_hi (req_addr[ADDR_W-1:IDX_LSB]),
        .win     (win),
        .idx     (idx),
        .hit     (hit)
    );

    assign sel     = idx[SEL_W-1:0];
    assign sel_val = hit ? st_q.regs[sel] : '0;

    regbank_bitop #(
        .DATA_W (DATA_W)
    ) u_bitop (
        .op   (win),
        .cur  (sel_val),
        .mask (req_wdata),
        .nxt  (upd_val)
    );

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = accept && !req_write;
        if (accept && !req_write) begin
            st_d.rsp_rdata = sel_val;
        end
        for (int k = 0; k < NUM_REGS; k++) begin
            if (accept && req_write && hit && (32'(sel) == 32'(k))) begin
                st_d.regs[k] = upd_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
            assign regs_out[g*DATA_W +: DATA_W] = st_q.regs[g];
        end
    endgenerate

    // ---------------- assertions ----------------
    assert_plain_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && hit && win == WIN_PLAIN)
        |=> st_q.regs[$past(sel)] == $past(req_wdata));

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && hit && win == WIN_SET)
        |=> st_q.regs[$past(sel)] == ($past(sel_val) | $past(req_wdata)));

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && hit && win == WIN_CLEAR)
        |=> st_q.regs[$past(sel)] == ($past(sel_val) & ~$past(req_wdata)));

    assert_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && hit && win == WIN_TOGGLE)
        |=> st_q.regs[$past(sel)] == ($past(sel_val) ^ $past(req_wdata)));

    assert_read_R5: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write)
        |=> (rsp_valid && $stable(regs_out) && rsp_rdata == $past(sel_val)));

    assert_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && hit && win != WIN_PLAIN)
        |=> ((st_q.regs[$past(sel)] ^ $past(sel_val)) & ~$past(req_wdata)) == '0);

    assert_miss_wr_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && req_write && !hit) |=> $stable(regs_out));

    assert_miss_rd_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !req_write && !hit) |=> (rsp_valid && rsp_rdata == '0));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (regs_out == '0 && !rsp_valid));

endmodule

// File: tb/test_regbank_alias.sv
module test_regbank_alias;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic                 req_write = 1'b0;
    logic [13:0]          req_addr  = '0;
    logic [31:0]          req_wdata = '0;
    logic                 rsp_valid;
    logic [31:0]          rsp_rdata;
    logic [NREG*32-1:0]   regs_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regbank_alias #(.NUM_REGS(NREG)) i_regbank_alias (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .regs_out  (regs_out)
    );

    typedef struct packed {
        logic        wr;
        logic [13:0] addr;
        logic [31:0] wdata;
        logic [13:0] chk;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 14'h0004, 32'h1234_5678, 14'h0004, 32'h1234_5678}, // R1 plain write reg1
        '{1'b1, 14'h2004, 32'h0000_0080, 14'h0004, 32'h1234_56F8}, // R2 set bit 7
        '{1'b1, 14'h3004, 32'h0000_0018, 14'h0004, 32'h1234_56E0}, // R3 clear
        '{1'b1, 14'h1004, 32'hFFFF_0000, 14'h0004, 32'hEDCB_56E0}, // R4 toggle
        '{1'b0, 14'h0000, 32'h0000_0000, 14'h2004, 32'hEDCB_56E0}, // R5 read via set window
        '{1'b1, 14'h001C, 32'hA5A5_A5A5, 14'h301C, 32'hA5A5_A5A5}, // R1 reg7, R5 read via clear window
        '{1'b1, 14'h201C, 32'h0000_0000, 14'h001C, 32'hA5A5_A5A5}, // R6 zero mask
        '{1'b1, 14'h301C, 32'hFFFF_FFFF, 14'h101C, 32'h0000_0000}, // R3 clear all
        '{1'b1, 14'h0020, 32'hDEAD_BEEF, 14'h0020, 32'h0000_0000}, // R7 miss write, miss read
        '{1'b1, 14'h3FFC, 32'hFFFF_FFFF, 14'h0004, 32'hEDCB_56E0}, // R7 miss clear leaves reg1
        '{1'b0, 14'h0000, 32'h0000_0000, 14'h0000, 32'h0000_0000}  // R7 reg0 untouched
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
        if (!rsp_valid) begin
            n_tests++; n_fail++;
            $display("FAIL R5: actual rsp_valid 0 expected 1");
        end
        d = rsp_rdata;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] cur;
        logic [31:0] fmask;
        logic [31:0] fnew;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state and ready
        check("R9 regs_out after reset", regs_out[31:0] | regs_out[NREG*32-1:NREG*32-32], 32'h0);
        check("R9 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        check("R9 req_ready", {31'b0, req_ready}, 32'h1);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].wdata);
            bus_read(VECS[i].chk, rd);
            check($sformatf("vector %0d", i), rd, VECS[i].exp);
        end
        check("R9 regs_out reg1 slice", regs_out[32 +: 32], 32'hEDCB_56E0);

        // R8 toggle then set back to back on reg3 (reverse order gives 0x2)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h100C; req_wdata = 32'h3;
        @(negedge clk);
        req_addr = 14'h200C; req_wdata = 32'h1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R8 toggle then set", regs_out[3*32 +: 32], 32'h3);

        // R8 set then clear back to back on reg2
        bus_write(14'h0008, 32'h0000_00F0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 14'h2008; req_wdata = 32'h0F;
        @(negedge clk);
        req_addr = 14'h3008; req_wdata = 32'h05;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        bus_read(14'h0008, rd);
        check("R8 set then clear", rd, 32'h0000_00FA);

        // R6 masked field update through one toggle write
        bus_write(14'h0010, 32'hCAFE_1234);
        bus_read(14'h0010, cur);
        fmask = 32'h0000_FF00;
        fnew  = 32'h0000_5A00;
        bus_write(14'h1010, (cur ^ fnew) & fmask);
        bus_read(14'h0010, rd);
        check("R6 field value", rd, 32'hCAFE_5A34);
        check("R6 outside mask unchanged", rd & ~fmask, cur & ~fmask);

        // R5 read causes no change
        bus_read(14'h3010, rd);
        check("R5 clear-window read value", rd, 32'hCAFE_5A34);
        check("R5 no side effect", regs_out[4*32 +: 32], 32'hCAFE_5A34);

        // R9 reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset clears reg4", regs_out[4*32 +: 32], 32'h0);
        check("R9 reset clears reg1", regs_out[32 +: 32], 32'h0);

        finish_run();
    end

endmodule